// File: doc/BRIEF.md
# Capability Presence Summary Bitmap

This block holds one conservative presence bit for each fixed-size region of a tagged memory. A bit that is set means the region may hold at least one valid capability tag. A bit that is clear means the region is known to hold none. The block watches tag writes on the memory side. Any write that sets a tag also marks that write's region as occupied. A tag-clearing write leaves the region's bit alone. A bit goes back to clear only when a sweeper, having confirmed that the region is empty, issues an explicit clear for that region.

Two read paths serve the sweeper, and both are combinational from the stored bits. The address query returns the presence bit of the region that contains a byte address. The find-next path takes a starting region index and returns the lowest occupied region at or above it, together with a valid flag. A sweep can therefore jump straight across runs of empty regions instead of visiting every 64-bit word. The region size is a parameter. The default gives a 128 KiB memory with 4 KiB regions, which is 32 summary bits.

Top module: `cps_summary`

## Requirements
- R1: After reset every presence bit is 0, so a query returns 0 and find-next reports no hit.
- R2: A tag write with `tag_wr_valid_i`=1 and `tag_wr_tag_i`=1 sets the bit of region `tag_wr_addr_i[REGION_SHIFT +: IDX_W]` at the clock edge where it is presented. The new value is visible from the next cycle. When `tag_wr_valid_i`=0 the tag write inputs have no effect.
- R3: A tag write with `tag_wr_tag_i`=0 never clears a presence bit and never sets one.
- R4: A clear command (`clr_valid_i`=1) clears the bit of region `clr_region_i` at that edge and leaves every other bit unchanged. Apart from this command, nothing clears a bit.
- R5: When a tag-setting write and a clear command name the same region in the same cycle, the bit ends up set. When they name different regions, both take effect.
- R6: `query_hit_o` equals the presence bit of the region that contains `query_addr_i`, with the region index taken from address bits `[REGION_SHIFT +: IDX_W]`. It is combinational.
- R7: `next_valid_o`=1 and `next_region_o` equals the lowest set region index that is greater than or equal to `next_from_i`, whenever such a region exists. It is combinational.
- R8: When no bit at or above `next_from_i` is set, `next_valid_o`=0 and `next_region_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tag_wr_valid_i | input | 1 | A tag write is presented this cycle |
| tag_wr_addr_i | input | ADDR_W | Byte address of the tag write |
| tag_wr_tag_i | input | 1 | Tag value written (1 = capability stored) |
| clr_valid_i | input | 1 | Clear command for one region |
| clr_region_i | input | IDX_W | Region index to clear |
| query_addr_i | input | ADDR_W | Byte address to look up |
| query_hit_o | output | 1 | Presence bit of the queried region |
| next_from_i | input | IDX_W | First region index to search from |
| next_valid_o | output | 1 | An occupied region exists at or above the start |
| next_region_o | output | IDX_W | Lowest occupied region index at or above the start |

## Verification
The bench targets a set and a clear that land on the same region in the same cycle. A design that lets the clear win would lose a live capability, and the sweeper would then skip a region that still holds one. Tag-clearing writes and writes with the valid flag low must leave the bitmap untouched; a design that clears on a zero tag would open the same hole. Find-next is probed with the start index exactly on a set bit, just past one, at the top region 31, and where nothing above is set. These probes expose an off-by-one in the start mask or a wrong no-hit encoding. Queries use the last byte of a region to catch a wrong split of the address bits.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
    // default geometry: 128 KiB of memory split into 4 KiB regions
    localparam int unsigned DEF_ADDR_W       = 17;
    localparam int unsigned DEF_REGION_SHIFT = 12;

    // per-region update request produced by the decoder
    typedef struct packed {
        logic set_hit;
        logic clr_hit;
    } upd_t;
endpackage

// File: rtl/cps_decode.sv
`timescale 1ns/1ps
module cps_decode
    import cps_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 32,
    parameter int unsigned IDX_W       = 5
) (
    input  logic             wr_set_i,
    input  logic [IDX_W-1:0] wr_region_i,
    input  logic             clr_i,
    input  logic [IDX_W-1:0] clr_region_i,
    output upd_t             upd_o [NUM_REGIONS]
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        assign upd_o[g].set_hit = wr_set_i && (wr_region_i == IDX_W'(g));
        assign upd_o[g].clr_hit = clr_i    && (clr_region_i == IDX_W'(g));
    end
endmodule

// File: rtl/cps_find_next.sv
`timescale 1ns/1ps
module cps_find_next #(
    parameter int unsigned NUM_REGIONS = 32,
    parameter int unsigned IDX_W       = 5
) (
    input  logic [NUM_REGIONS-1:0] present_i,
    input  logic [IDX_W-1:0]       from_i,
    output logic                   found_o,
    output logic [IDX_W-1:0]       index_o
);
    logic [NUM_REGIONS-1:0] masked;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_mask
        assign masked[g] = present_i[g] && (IDX_W'(g) >= from_i);
    end

    always_comb begin
        index_o = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (masked[i]) begin
                index_o = IDX_W'(i);
            end
        end
        found_o = |masked;
    end
endmodule

// File: rtl/cps_summary.sv
`timescale 1ns/1ps
module cps_summary
    import cps_pkg::*;
#(
    parameter int unsigned ADDR_W       = DEF_ADDR_W,
    parameter int unsigned REGION_SHIFT = DEF_REGION_SHIFT,
    localparam int unsigned IDX_W       = ADDR_W - REGION_SHIFT,
    localparam int unsigned NUM_REGIONS = 1 << IDX_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tag_wr_valid_i,
    input  logic [ADDR_W-1:0] tag_wr_addr_i,
    input  logic              tag_wr_tag_i,
    input  logic              clr_valid_i,
    input  logic [IDX_W-1:0]  clr_region_i,
    input  logic [ADDR_W-1:0] query_addr_i,
    output logic              query_hit_o,
    input  logic [IDX_W-1:0]  next_from_i,
    output logic              next_valid_o,
    output logic [IDX_W-1:0]  next_region_o
);
    typedef struct packed {
        logic [NUM_REGIONS-1:0] present;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0] wr_region;
    logic [IDX_W-1:0] query_region;
    logic             wr_set;
    upd_t             upd [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] present_vec;

    assign wr_region    = IDX_W'(tag_wr_addr_i >> REGION_SHIFT);
    assign query_region = IDX_W'(query_addr_i >> REGION_SHIFT);
    assign wr_set       = tag_wr_valid_i && tag_wr_tag_i;
    assign present_vec  = state_q.present;

    cps_decode #(
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) u_decode (
        .wr_set_i    (wr_set),
        .wr_region_i (wr_region),
        .clr_i       (clr_valid_i),
        .clr_region_i(clr_region_i),
        .upd_o       (upd)
    );

    // next-state: a set on a region beats a clear on that region
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (upd[i].set_hit) begin
                state_d.present[i] = 1'b1;
            end else if (upd[i].clr_hit) begin
                state_d.present[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign query_hit_o = present_vec[query_region];

    cps_find_next #(
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) u_find (
        .present_i(present_vec),
        .from_i   (next_from_i),
        .found_o  (next_valid_o),
        .index_o  (next_region_o)
    );
endmodule

// File: rtl/cps_summary_chk.sv
`timescale 1ns/1ps
module cps_summary_chk #(
    parameter int unsigned ADDR_W       = 17,
    parameter int unsigned REGION_SHIFT = 12,
    localparam int unsigned IDX_W       = ADDR_W - REGION_SHIFT,
    localparam int unsigned NUM_REGIONS = 1 << IDX_W
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   tag_wr_valid_i,
    input logic [ADDR_W-1:0]      tag_wr_addr_i,
    input logic                   tag_wr_tag_i,
    input logic                   clr_valid_i,
    input logic [IDX_W-1:0]       clr_region_i,
    input logic [NUM_REGIONS-1:0] present,
    input logic [IDX_W-1:0]       next_from_i,
    input logic                   next_valid_o,
    input logic [IDX_W-1:0]       next_region_o
);
    logic [IDX_W-1:0] wr_idx;
    logic             wr_set;
    assign wr_idx = IDX_W'(tag_wr_addr_i >> REGION_SHIFT);
    assign wr_set = tag_wr_valid_i && tag_wr_tag_i;

    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_set |=> present[$past(wr_idx)]); // R2

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_set && clr_valid_i && wr_idx == clr_region_i) |=> present[$past(clr_region_i)]); // R5

    AST_NO_STRAY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_set |=> ((present & ~$past(present)) == '0)); // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_valid_i && !(wr_set && wr_idx == clr_region_i)) |=> !present[$past(clr_region_i)]); // R4

    AST_NO_STRAY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_valid_i |=> ((~present & $past(present)) == '0)); // R4

    AST_FIND_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        next_valid_o |-> (present[next_region_o] && next_region_o >= next_from_i
                          && ((present & ((NUM_REGIONS'(1) << next_region_o) - 1'b1)
                               & ~((NUM_REGIONS'(1) << next_from_i) - 1'b1)) == '0))); // R7

    AST_FIND_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !next_valid_o |-> ((present >> next_from_i) == '0 && next_region_o == '0)); // R8
endmodule

bind cps_summary cps_summary_chk #(
    .ADDR_W      (ADDR_W),
    .REGION_SHIFT(REGION_SHIFT)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tag_wr_valid_i(tag_wr_valid_i),
    .tag_wr_addr_i (tag_wr_addr_i),
    .tag_wr_tag_i  (tag_wr_tag_i),
    .clr_valid_i   (clr_valid_i),
    .clr_region_i  (clr_region_i),
    .present       (present_vec),
    .next_from_i   (next_from_i),
    .next_valid_o  (next_valid_o),
    .next_region_o (next_region_o)
);

// File: tb/cps_summary_tb.sv
`timescale 1ns/1ps
module cps_summary_tb;
    localparam int AW = 17;
    localparam int RS = 12;
    localparam int IW = AW - RS;
    localparam int NR = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_tag = 1'b0;
    logic          clr_valid = 1'b0;
    logic [IW-1:0] clr_region = '0;
    logic [AW-1:0] q_addr = '0;
    logic          q_hit;
    logic [IW-1:0] from_idx = '0;
    logic          n_valid;
    logic [IW-1:0] n_region;

    always #5 clk = ~clk;

    cps_summary #(.ADDR_W(AW), .REGION_SHIFT(RS)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .tag_wr_valid_i(wr_valid), .tag_wr_addr_i(wr_addr), .tag_wr_tag_i(wr_tag),
        .clr_valid_i(clr_valid), .clr_region_i(clr_region),
        .query_addr_i(q_addr), .query_hit_o(q_hit),
        .next_from_i(from_idx), .next_valid_o(n_valid), .next_region_o(n_region)
    );

    typedef struct {
        logic          hit;
        logic          vld;
        logic [IW-1:0] idx;
        string         req;
    } item_t;

    item_t   sb[$];
    bit      model [NR];
    int      total = 0;
    int      bad = 0;
    bit      done = 1'b0;

    // driver: one write/clear cycle, model updated from the requirements
    task automatic step(input logic wv, input logic [AW-1:0] wa, input logic wt,
                        input logic cv, input logic [IW-1:0] cr);
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_tag = wt;
        clr_valid = cv; clr_region = cr;
        @(negedge clk);
        wr_valid = 1'b0; clr_valid = 1'b0;
        if (cv) model[cr] = 1'b0;
        if (wv && wt) model[int'(wa >> RS)] = 1'b1;
    endtask

    // driver: present a query and push the expected answer
    task automatic probe(input logic [AW-1:0] a, input logic [IW-1:0] f, input string req);
        item_t it;
        @(negedge clk);
        q_addr = a; from_idx = f;
        it.hit = model[int'(a >> RS)];
        it.vld = 1'b0;
        it.idx = '0;
        for (int i = NR - 1; i >= int'(f); i--) begin
            if (model[i]) begin
                it.vld = 1'b1;
                it.idx = IW'(i);
            end
        end
        it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compare after each rising edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if (q_hit !== it.hit || n_valid !== it.vld || n_region !== it.idx) begin
                    bad++;
                    $display("FAIL %s: hit=%0b valid=%0b idx=%0d expected hit=%0b valid=%0b idx=%0d",
                             it.req, q_hit, n_valid, n_region, it.hit, it.vld, it.idx);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe(17'h00000, 5'd0, "R1");                  // empty after reset
        probe(17'h1F000, 5'd0, "R1");
        step(1'b1, 17'h03008, 1'b1, 1'b0, 5'd0);       // set region 3
        probe(17'h03FF8, 5'd0, "R2");
        probe(17'h02FFF, 5'd3, "R6");                  // neighbour region miss, start on set bit
        probe(17'h00000, 5'd4, "R8");                  // start just past the only set bit
        step(1'b0, 17'h05000, 1'b1, 1'b0, 5'd0);       // valid low: ignored
        probe(17'h05000, 5'd4, "R2");
        step(1'b1, 17'h03010, 1'b0, 1'b0, 5'd0);       // zero tag on occupied region
        probe(17'h03000, 5'd0, "R3");
        step(1'b1, 17'h07000, 1'b0, 1'b0, 5'd0);       // zero tag on empty region
        probe(17'h07000, 5'd4, "R3");
        step(1'b1, 17'h1F008, 1'b1, 1'b0, 5'd0);       // set top region 31
        probe(17'h1FFFF, 5'd4, "R7");
        probe(17'h1F000, 5'd31, "R7");
        step(1'b0, 17'h00000, 1'b0, 1'b1, 5'd3);       // clear region 3
        probe(17'h03000, 5'd0, "R4");
        probe(17'h1F000, 5'd0, "R4");
        step(1'b1, 17'h0A100, 1'b1, 1'b1, 5'd10);      // set and clear on region 10
        probe(17'h0AFFF, 5'd10, "R5");
        step(1'b1, 17'h0C000, 1'b1, 1'b1, 5'd31);      // set 12, clear 31
        probe(17'h0C000, 5'd11, "R5");
        probe(17'h1F000, 5'd13, "R5");
        probe(17'h00000, 5'd13, "R8");
        step(1'b1, 17'h00000, 1'b1, 1'b0, 5'd0);       // set region 0
        probe(17'h00FFF, 5'd0, "R7");
        probe(17'h0B000, 5'd1, "R7");
        step(1'b0, 17'h00000, 1'b0, 1'b1, 5'd10);
        step(1'b0, 17'h00000, 1'b0, 1'b1, 5'd12);
        probe(17'h0A000, 5'd1, "R8");
        probe(17'h00000, 5'd0, "R4");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule